// File: doc/BRIEF.md
# Sixteen-Output Shared-Timebase PWM Controller

The block generates up to sixteen pulse-width-modulated outputs. All of them run from one 12-bit counter, so they share a single period. The host sets the block up through a byte-wide register port with an 8-bit address. A prescaler divides the clock so that the counter steps once every `prescale + 1` clocks, and one full period is therefore `(prescale + 1) * 4096` clocks.

Each channel holds an ON count, an OFF count and two override flags. The flags force the output permanently high or permanently low. Four broadcast addresses copy a single write into the matching register of every channel. A control byte puts the block to sleep, which stops the counter and silences the outputs. A second control byte can invert every output, and it chooses between push-pull drive and open-drain drive. In open-drain mode a high level is reported through an output-enable vector instead of being driven.

After reset the block is asleep and every channel is forced off. The host programs the prescaler while the block sleeps, then configures the channels, then clears the sleep flag. After a fixed wake-up delay the counter starts from zero.

Top module: `pwmc_top`

## Requirements
- R1: After reset, the control byte at 0x00 reads 0x10 (sleep set), the control byte at 0x01 reads 0x04 (push-pull, not inverted), and the prescale register at 0xFE reads 30. Every channel's OFF-high byte reads 0x10 and every other channel byte reads 0x00. All `pwm_out` bits are 0 and all `pwm_oe` bits are 1.
- R2: Channel n owns addresses 0x06+4n to 0x09+4n, holding ON bits 7:0, then ON bits 11:8, then OFF bits 7:0, then OFF bits 11:8. In each high byte, bits 3:0 hold the count's top nibble and bit 4 is the override flag. Bits 7:5 of a high byte read back as 0. Addresses 0xFA to 0xFD and unmapped addresses read as 0x00. A read returns its data on `reg_rdata` one clock after the read strobe.
- R3: A write to 0xFA, 0xFB, 0xFC or 0xFD stores the value into the ON-low, ON-high, OFF-low or OFF-high byte, respectively, of every channel.
- R4: A write to 0xFE is stored only while the sleep bit (bit 4 of 0x00) is set, and is ignored otherwise. A written value below 3 is stored as 3.
- R5: While awake, the counter advances once every `prescale + 1` clocks and wraps after 4095, so every output repeats every `(prescale + 1) * 4096` clocks.
- R6: With both override flags clear, a channel's level is high for counter values c where ON <= c < OFF when ON < OFF, or where c >= ON or c < OFF when ON > OFF. When ON equals OFF the level is always low.
- R7: The full-off flag (OFF-high bit 4) forces the level low whatever the other settings are. Otherwise the full-on flag (ON-high bit 4) forces it high, and the OFF count then has no effect.
- R8: Bit 4 of 0x01 inverts every `pwm_out` bit.
- R9: When bit 2 of 0x01 is 1, `pwm_oe` is all ones. When it is 0, each `pwm_oe` bit is the complement of its `pwm_out` bit, so a high output is not driven.
- R10: While asleep, the counter is held at 0 and every level is low. After the sleep bit is cleared, the counter stays at 0 for WAKE_CYCLES clocks before it starts counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, which also serves as the oscillator |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one clock after the read strobe |
| pwm_out | output | NUM_CH | Output levels after inversion |
| pwm_oe | output | NUM_CH | Output-enable; 0 means high-impedance |

## Verification
The assertions check several rules on every cycle. The prescaler stays fixed while the block is awake and never drops below its floor. A sleeping counter sits at zero. The full-off flag always wins, and the full-on flag wins when full-off is clear. The output-enable vector always matches the drive mode. Other behaviour needs the bench's scenarios to show it. The bench sweeps the counter over whole periods with channels set to normal, wrapping, equal and override settings, and checks each level against an expected value it computes from the counter. It also measures the period for two prescale values, checks broadcast fan-out and register readback, and times the wake-up delay.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;

    localparam int CNT_W     = 12;
    localparam int PRESC_MIN = 3;
    localparam int SLEEP_BIT = 4;
    localparam int INV_BIT   = 4;
    localparam int DRV_BIT   = 2;
    localparam int FLAG_BIT  = 4;

    localparam logic [7:0] A_CTRL0  = 8'h00;
    localparam logic [7:0] A_CTRL1  = 8'h01;
    localparam logic [7:0] A_CHBASE = 8'h06;
    localparam logic [7:0] A_BCLO   = 8'hFA;
    localparam logic [7:0] A_BCHI   = 8'hFD;
    localparam logic [7:0] A_PRESC  = 8'hFE;

    typedef struct packed {
        logic [CNT_W-1:0] on_cnt;
        logic [CNT_W-1:0] off_cnt;
        logic             force_on;
        logic             force_off;
    } chan_cfg_t;

    localparam chan_cfg_t CFG_RST = '{on_cnt: '0, off_cnt: '0, force_on: 1'b0, force_off: 1'b1};

    // byte lane: 0 ON low, 1 ON high, 2 OFF low, 3 OFF high
    function automatic chan_cfg_t cfg_write(chan_cfg_t c, logic [1:0] lane, logic [7:0] v);
        chan_cfg_t r = c;
        case (lane)
            2'd0: r.on_cnt[7:0] = v;
            2'd1: begin r.on_cnt[CNT_W-1:8] = v[3:0]; r.force_on = v[FLAG_BIT]; end
            2'd2: r.off_cnt[7:0] = v;
            default: begin r.off_cnt[CNT_W-1:8] = v[3:0]; r.force_off = v[FLAG_BIT]; end
        endcase
        return r;
    endfunction

    function automatic logic [7:0] cfg_read(chan_cfg_t c, logic [1:0] lane);
        case (lane)
            2'd0:    return c.on_cnt[7:0];
            2'd1:    return {3'b000, c.force_on, c.on_cnt[CNT_W-1:8]};
            2'd2:    return c.off_cnt[7:0];
            default: return {3'b000, c.force_off, c.off_cnt[CNT_W-1:8]};
        endcase
    endfunction

endpackage

// File: rtl/pwmc_regs.sv
module pwmc_regs
    import pwmc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int PRESC_RST = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [7:0]              addr,
    input  logic [7:0]              wdata,
    output logic [7:0]              rdata,
    output logic                    sleep,
    output logic                    invert,
    output logic                    push_pull,
    output logic [7:0]              presc,
    output chan_cfg_t [NUM_CH-1:0]  cfg
);

    localparam logic [8:0] CH_END = 9'(int'(A_CHBASE) + 4 * NUM_CH);

    typedef struct packed {
        logic [7:0]             ctrl0;
        logic [7:0]             ctrl1;
        logic [7:0]             presc;
        logic [7:0]             rdata;
        chan_cfg_t [NUM_CH-1:0] ch;
    } regs_t;

    regs_t q, d;

    logic       ch_hit, bc_hit;
    logic [7:0] rel;
    logic [1:0] lane;

    always_comb begin
        logic [7:0] rd_val;
        rel    = addr - A_CHBASE;
        lane   = addr[1:0] - 2'd2;
        ch_hit = (addr >= A_CHBASE) && ({1'b0, addr} < CH_END);
        bc_hit = (addr >= A_BCLO) && (addr <= A_BCHI);
        d      = q;
        rd_val = 8'h00;

        if (wr_en) begin
            if (addr == A_CTRL0) d.ctrl0 = wdata;
            if (addr == A_CTRL1) d.ctrl1 = wdata;
            if (addr == A_PRESC && q.ctrl0[SLEEP_BIT])
                d.presc = (wdata < 8'(PRESC_MIN)) ? 8'(PRESC_MIN) : wdata;
        end
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_en && (bc_hit || (ch_hit && rel[7:2] == 6'(i))))
                d.ch[i] = cfg_write(q.ch[i], lane, wdata);
            if (ch_hit && rel[7:2] == 6'(i))
                rd_val = cfg_read(q.ch[i], lane);
        end
        if (addr == A_CTRL0) rd_val = q.ctrl0;
        if (addr == A_CTRL1) rd_val = q.ctrl1;
        if (addr == A_PRESC) rd_val = q.presc;
        if (rd_en) d.rdata = rd_val;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.ctrl0 <= 8'h10;
            q.ctrl1 <= 8'h04;
            q.presc <= 8'(PRESC_RST);
            q.rdata <= 8'h00;
            for (int i = 0; i < NUM_CH; i++) q.ch[i] <= CFG_RST;
        end else begin
            q <= d;
        end
    end

    assign rdata     = q.rdata;
    assign sleep     = q.ctrl0[SLEEP_BIT];
    assign invert    = q.ctrl1[INV_BIT];
    assign push_pull = q.ctrl1[DRV_BIT];
    assign presc     = q.presc;
    assign cfg       = q.ch;

    AST_PRESC_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !q.ctrl0[SLEEP_BIT] |=> $stable(q.presc)); // R4
    AST_PRESC_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        q.presc >= 8'(PRESC_MIN)); // R4

endmodule

// File: rtl/pwmc_timebase.sv
module pwmc_timebase
    import pwmc_pkg::*;
#(
    parameter int WAKE_CYCLES = 12500
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic [7:0]       presc,
    output logic [CNT_W-1:0] cnt,
    output logic             run
);

    localparam int WW = $clog2(WAKE_CYCLES + 1);

    typedef struct packed {
        logic [WW-1:0]    wake;
        logic [7:0]       div;
        logic [CNT_W-1:0] cnt;
        logic             run;
    } tb_t;

    tb_t q, d;

    always_comb begin
        d = q;
        if (sleep) begin
            d.wake = '0;
            d.div  = '0;
            d.cnt  = '0;
            d.run  = 1'b0;
        end else if (!q.run) begin
            if (q.wake == WW'(WAKE_CYCLES - 1)) d.run  = 1'b1;
            else                                d.wake = q.wake + WW'(1);
        end else if (q.div == presc) begin
            d.div = '0;
            d.cnt = q.cnt + CNT_W'(1);
        end else begin
            d.div = q.div + 8'd1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign cnt = q.cnt;
    assign run = q.run;

    AST_ASLEEP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> (q.cnt == '0 && !q.run)); // R10

endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan
    import pwmc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] cnt,
    input  chan_cfg_t        cfg,
    output logic             lvl
);

    logic lvl_q, lvl_d, in_win;

    always_comb begin
        if (cfg.on_cnt < cfg.off_cnt)
            in_win = (cnt >= cfg.on_cnt) && (cnt < cfg.off_cnt);
        else if (cfg.on_cnt > cfg.off_cnt)
            in_win = (cnt >= cfg.on_cnt) || (cnt < cfg.off_cnt);
        else
            in_win = 1'b0;
        lvl_d = run && !cfg.force_off && (cfg.force_on || in_win);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign lvl = lvl_q;

    AST_FULL_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg.force_off |=> !lvl_q); // R7
    AST_FULL_ON_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg.force_on && !cfg.force_off) |=> lvl_q); // R7

endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
    import pwmc_pkg::*;
#(
    parameter int NUM_CH      = 16,
    parameter int WAKE_CYCLES = 12500,
    parameter int PRESC_RST   = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic [NUM_CH-1:0] pwm_out,
    output logic [NUM_CH-1:0] pwm_oe
);

    logic                   sleep, invert, push_pull, run;
    logic [7:0]             presc;
    logic [CNT_W-1:0]       cnt;
    chan_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0]      lvl;

    pwmc_regs #(.NUM_CH(NUM_CH), .PRESC_RST(PRESC_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .rd_en(reg_rd),
        .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .sleep(sleep), .invert(invert), .push_pull(push_pull),
        .presc(presc), .cfg(cfg)
    );

    pwmc_timebase #(.WAKE_CYCLES(WAKE_CYCLES)) u_tb (
        .clk(clk), .rst_n(rst_n), .sleep(sleep), .presc(presc),
        .cnt(cnt), .run(run)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwmc_chan u_chan (
            .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
            .cfg(cfg[g]), .lvl(lvl[g])
        );
    end

    always_comb begin
        pwm_out = lvl ^ {NUM_CH{invert}};
        pwm_oe  = push_pull ? {NUM_CH{1'b1}} : ~pwm_out;
    end

    AST_PP_DRIVES_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        push_pull |-> (&pwm_oe)); // R9
    AST_OD_HIGHZ: assert property (@(posedge clk) disable iff (!rst_n)
        !push_pull |-> ((pwm_oe & pwm_out) == '0)); // R9

endmodule

// File: tb/pwmc_top_bench.sv
module pwmc_top_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 16;
    localparam int WAKE  = 40;
    localparam int REF   = 15;
    localparam logic [15:0] OVR_MASK = 16'h001C;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_addr = 8'h00, reg_wdata = 8'h00, reg_rdata;
    logic [NCH-1:0] pwm_out, pwm_oe;

    int n_chk = 0, n_bad = 0;
    int e_on[NCH], e_off[NCH];
    bit e_fon[NCH], e_foff[NCH];

    always #(CLK_P/2) clk = ~clk;

    pwmc_top #(.NUM_CH(NCH), .WAKE_CYCLES(WAKE), .PRESC_RST(30)) u_pwmc_top (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pwm_out(pwm_out), .pwm_oe(pwm_oe)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] v);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; v = reg_rdata;
    endtask

    function automatic bit exp_lvl(int i, int c);
        if (e_foff[i]) return 1'b0;
        if (e_fon[i]) return 1'b1;
        if (e_on[i] == e_off[i]) return 1'b0;
        if (e_on[i] < e_off[i]) return (c >= e_on[i]) && (c < e_off[i]);
        return (c >= e_on[i]) || (c < e_off[i]);
    endfunction

    function automatic logic [NCH-1:0] exp_vec(int c);
        logic [NCH-1:0] v;
        for (int i = 0; i < NCH; i++) v[i] = exp_lvl(i, c);
        return v;
    endfunction

    // wait for the reference channel's logical rise; pol=1 when inverted
    task automatic wait_ref_rise(input bit pol, output int waited);
        logic prev, cur;
        waited = 0;
        prev = pwm_out[REF] ^ pol;
        forever begin
            @(negedge clk); waited++;
            cur = pwm_out[REF] ^ pol;
            if (!prev && cur) break;
            prev = cur;
        end
    endtask

    task automatic sweep(input int p, input bit pol, input string tag);
        int bad_win = 0, bad_ovr = 0, bad_inv = 0, bad_oe = 0, w;
        logic [NCH-1:0] e;
        wait_ref_rise(pol, w);
        for (int k = 0; k < (p + 1) * 4096; k++) begin
            if (k > 0) @(negedge clk);
            e = exp_vec((k / (p + 1)) % 4096);
            if (((pwm_out ^ {NCH{pol}}) & ~OVR_MASK) != (e & ~OVR_MASK)) bad_win++;
            if (((pwm_out ^ {NCH{pol}}) & OVR_MASK) != (e & OVR_MASK)) bad_ovr++;
            if (pol && pwm_out != ~e) bad_inv++;
            if (pol && pwm_oe != e) bad_oe++;
        end
        check({"R6 window sweep ", tag}, bad_win, 0);
        check({"R7 override sweep ", tag}, bad_ovr, 0);
        if (pol) begin
            check("R8 inverted levels", bad_inv, 0);
            check("R9 open-drain enables", bad_oe, 0);
        end
    endtask

    task automatic measure_period(output int cyc);
        int w;
        wait_ref_rise(1'b0, w);
        wait_ref_rise(1'b0, cyc);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog R5 actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        int w, per;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 pwm_out", int'(pwm_out), 0);
        check("R1 pwm_oe", int'(pwm_oe), 16'hFFFF);
        rd(8'h00, v); check("R1 ctrl0", v, 8'h10);
        rd(8'h01, v); check("R1 ctrl1", v, 8'h04);
        rd(8'hFE, v); check("R1 prescale", v, 30);
        rd(8'h06 + 8'd4*5 + 8'd3, v); check("R1 off-high flag", v, 8'h10);
        rd(8'h06 + 8'd4*9, v); check("R1 on-low", v, 8'h00);

        // R2 readback masking and zero reads
        wr(8'h06 + 8'd4*3 + 8'd1, 8'hFF);
        rd(8'h06 + 8'd4*3 + 8'd1, v); check("R2 high byte mask", v, 8'h1F);
        rd(8'h02, v); check("R2 unmapped 0x02", v, 8'h00);
        rd(8'hFF, v); check("R2 unmapped 0xFF", v, 8'h00);
        rd(8'h46, v); check("R2 unmapped 0x46", v, 8'h00);

        // R3 broadcast
        wr(8'hFA, 8'hA5);
        wr(8'hFD, 8'h03);
        rd(8'hFA, v); check("R2 broadcast reads zero", v, 8'h00);
        begin
            int bad_bc = 0;
            for (int i = 0; i < NCH; i++) begin
                rd(8'(6 + 4*i), v); if (v != 8'hA5) bad_bc++;
                rd(8'(9 + 4*i), v); if (v != 8'h03) bad_bc++;
            end
            check("R3 broadcast fan-out", bad_bc, 0);
        end

        // R4 prescale while asleep, with floor
        wr(8'hFE, 8'h01); rd(8'hFE, v); check("R4 prescale floor", v, 3);
        wr(8'hFE, 8'h03); rd(8'hFE, v); check("R4 prescale stored asleep", v, 3);

        for (int i = 0; i < NCH; i++) begin
            e_on[i] = (i * 263) % 4096;
            e_off[i] = (i * 263 + 700 + i * 50) % 4096;
            e_fon[i] = 0; e_foff[i] = 0;
        end
        e_on[0] = 1000; e_off[0] = 1000;
        e_on[1] = 3000; e_off[1] = 500;
        e_fon[2] = 1; e_on[2] = 0; e_off[2] = 100;
        e_foff[3] = 1; e_on[3] = 10; e_off[3] = 3000;
        e_fon[4] = 1; e_foff[4] = 1;
        e_on[5] = 0; e_off[5] = 4095;
        e_on[6] = 4095; e_off[6] = 0;
        e_on[REF] = 0; e_off[REF] = 2048;
        for (int i = 0; i < NCH; i++) begin
            wr(8'(6 + 4*i), 8'(e_on[i] & 255));
            wr(8'(7 + 4*i), 8'({e_fon[i], 4'(e_on[i] >> 8)}));
            wr(8'(8 + 4*i), 8'(e_off[i] & 255));
            wr(8'(9 + 4*i), 8'({e_foff[i], 4'(e_off[i] >> 8)}));
        end

        // R10 quiet while asleep, then wake delay
        repeat (50) @(negedge clk);
        check("R10 asleep outputs low", int'(pwm_out), 0);
        wr(8'h00, 8'h00);
        wait_ref_rise(1'b0, w);
        n_chk++;
        if (w < WAKE - 1 || w > WAKE + 3) begin
            n_bad++;
            $display("FAIL R10 wake delay actual=%0d expected=%0d..%0d", w, WAKE - 1, WAKE + 3);
        end

        // R6, R7 sweep at prescale 3; the rise just seen starts the period
        begin
            int bad_win = 0, bad_ovr = 0;
            logic [NCH-1:0] e;
            for (int k = 0; k < 4 * 4096; k++) begin
                if (k > 0) @(negedge clk);
                e = exp_vec(k / 4);
                if ((pwm_out & ~OVR_MASK) != (e & ~OVR_MASK)) bad_win++;
                if ((pwm_out & OVR_MASK) != (e & OVR_MASK)) bad_ovr++;
            end
            check("R6 window sweep p=3", bad_win, 0);
            check("R7 override sweep p=3", bad_ovr, 0);
        end

        // R5 period at prescale 3
        measure_period(per); check("R5 period p=3", per, 4 * 4096);

        // R4 ignored while awake
        wr(8'hFE, 8'h07); rd(8'hFE, v); check("R4 prescale locked awake", v, 3);

        // R5 period at prescale 4
        wr(8'h00, 8'h10);
        wr(8'hFE, 8'h04);
        wr(8'h00, 8'h00);
        measure_period(per); check("R5 period p=4", per, 5 * 4096);

        // R8, R9 inverted open-drain sweep
        wr(8'h01, 8'h10);
        sweep(4, 1'b1, "inverted");
        wr(8'h01, 8'h04);
        @(negedge clk);
        check("R9 push-pull enables", int'(pwm_oe), 16'hFFFF);

        // R10 sleep silences outputs
        wr(8'h00, 8'h10);
        repeat (200) @(negedge clk);
        check("R10 sleep silences outputs", int'(pwm_out), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule